// File: doc/BRIEF.md
# Configuration Bitstream Admission Controller

This block is the policy logic that decides whether a configuration bitstream may load the device. It owns two 256-bit key slots and a sticky tamper-protection latch. The first slot is volatile: it can be written, erased and rewritten any number of times. The second slot is one-time-programmable: its first write sticks, and every later write is ignored. A separate decryptor compares the incoming stream against the selected key and reports the result as a single match bit. Every bitstream is announced by a one-cycle start pulse. With that pulse come the stream's header attributes: encrypted or plain, compressed or not, and whether it arrives over the JTAG path or the normal serial/parallel path.

For each announced stream the controller either admits it or refuses it. When it admits a stream, it sets the data routing: whether the decryptor is bypassed, whether the decompressor is used, and whether the decompressor takes the decryptor's output. The order is always decrypt first, then decompress. When it refuses a stream, it raises a one-cycle error strobe and holds an active-low status line low for a programmable number of cycles. During that time it ignores new start pulses, and afterwards it waits for the next one. Once the tamper latch is set it can never be cleared. From then on, plain streams and JTAG configuration are refused, and a test-mode-disable output stays high.

Top module: `cfg_admit_ctrl`

## Requirements
- R1: Volatile slot: a write loads `key_in` and sets `vol_key_valid`. An erase clears the key and the valid flag, and wins over a write in the same cycle. The slot can be rewritten after an erase.
- R2: One-time slot: the first write loads `key_in` and sets `nv_key_valid`. Any later write leaves the stored key unchanged. A volatile erase does not affect this slot.
- R3: `key_out` shows the one-time slot's key when that slot is valid, otherwise the volatile key when that slot is valid, otherwise all zeros.
- R4: With the tamper latch clear, a plain stream (`bs_encrypted`=0) on the normal path is admitted with `dec_bypass`=1, whether or not any key is stored.
- R5: An encrypted stream on the normal path is admitted only when at least one slot is valid and `bs_key_ok`=1. It is then routed with `dec_bypass`=0.
- R6: An encrypted stream on the normal path with `bs_key_ok`=0, or with no valid slot, is refused.
- R7: With the tamper latch set, plain streams and JTAG streams are refused. Encrypted streams with a valid key and a match are still admitted.
- R8: An admitted JTAG stream (`bs_from_jtag`=1) always gets `dec_bypass`=1, even when `bs_encrypted`=1.
- R9: A `tamper_set` pulse sets the tamper latch from the next cycle on. `test_mode_dis` then stays 1 until reset, whatever the inputs do.
- R10: On a refusal, `reject_err` is high for exactly one cycle, the cycle after the start pulse. `status_n` is low for exactly PULSE_LEN cycles (default 16), starting in that same cycle. Start pulses during that window are ignored. A start after the window is decided normally.
- R11: On admission, `dcmp_en` equals `bs_compressed`, and `dcmp_after_dec`=1 exactly when the stream is both compressed and decrypted. These route outputs hold until the next decision. A refusal returns them to `dec_bypass`=1, `dcmp_en`=0, `dcmp_after_dec`=0, which is also their reset state.
- R12: `accept` is high for exactly one cycle, the cycle after an admitted start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vol_key_wr | input | 1 | Write `key_in` into the volatile slot |
| vol_key_erase | input | 1 | Erase the volatile slot |
| nv_key_wr | input | 1 | Write `key_in` into the one-time slot |
| key_in | input | KEY_W | Key value to store |
| tamper_set | input | 1 | Set the tamper-protection latch |
| bs_start | input | 1 | One-cycle pulse announcing a bitstream |
| bs_encrypted | input | 1 | Header flag: stream is encrypted |
| bs_key_ok | input | 1 | Decryptor reports that the stream matches the stored key |
| bs_from_jtag | input | 1 | Stream arrives over the JTAG path |
| bs_compressed | input | 1 | Header flag: stream is compressed |
| accept | output | 1 | One-cycle admit pulse |
| reject_err | output | 1 | One-cycle refusal strobe |
| status_n | output | 1 | Active-low status, low during the refusal window |
| dec_bypass | output | 1 | Route the data around the decryptor |
| dcmp_en | output | 1 | Decompressor in the data path |
| dcmp_after_dec | output | 1 | Decompressor fed from the decryptor output |
| key_out | output | KEY_W | Key presented to the decryptor |
| vol_key_valid | output | 1 | Volatile slot holds a key |
| nv_key_valid | output | 1 | One-time slot holds a key |
| test_mode_dis | output | 1 | Test mode disabled, set by the tamper latch |

## Verification
The assertions assume that `bs_start` is a single-cycle pulse and that its header attributes and `bs_key_ok` are valid in that same cycle. They also assume that `tamper_set` and the key-write strobes are pulses and do not coincide with a start pulse they are meant to influence. The bench drives every input on the falling edge and holds each header field only for its start cycle. It leaves at least one idle cycle after a tamper or key write before the next stream, and it deliberately places one start pulse inside a refusal window to show that the pulse is ignored.

// File: rtl/cfg_adm_pkg.sv
package cfg_adm_pkg;

  typedef struct packed {
    logic admit;
    logic dec_byp;
    logic dcmp_en;
    logic dcmp_chain;
  } route_t;

  localparam route_t ROUTE_IDLE = '{admit: 1'b0, dec_byp: 1'b1, dcmp_en: 1'b0, dcmp_chain: 1'b0};

  // Admission rule plus data routing for one announced bitstream.
  function automatic route_t decide(input logic enc, input logic key_ok,
                                    input logic jtag, input logic cmp,
                                    input logic any_key, input logic tamper);
    route_t r;
    r = ROUTE_IDLE;
    if (jtag) begin
      r.admit = !tamper;
    end else if (enc) begin
      if (any_key && key_ok) begin
        r.admit   = 1'b1;
        r.dec_byp = 1'b0;
      end
    end else begin
      r.admit = !tamper;
    end
    if (r.admit) begin
      r.dcmp_en    = cmp;
      r.dcmp_chain = cmp && !r.dec_byp;
    end
    return r;
  endfunction

endpackage

// File: rtl/cfg_key_slot.sv
module cfg_key_slot #(
  parameter int KEY_W    = 256,
  parameter bit ONE_TIME = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             clr,
  input  logic [KEY_W-1:0] din,
  output logic [KEY_W-1:0] key,
  output logic             valid
);

  logic load_ok;
  logic clr_ok;

  assign load_ok = wr && !(ONE_TIME && valid);
  assign clr_ok  = clr && !ONE_TIME;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key   <= '0;
      valid <= 1'b0;
    end else if (clr_ok) begin
      key   <= '0;
      valid <= 1'b0;
    end else if (load_ok) begin
      key   <= din;
      valid <= 1'b1;
    end
  end

  generate
    if (ONE_TIME) begin : g_otp
      AST_OTP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && wr) |=> ($stable(key) && valid)); // R2
    end else begin : g_vol
      AST_ERASE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!valid && key == '0)); // R1
    end
  endgenerate

endmodule

// File: rtl/cfg_adm_policy.sv
module cfg_adm_policy
  import cfg_adm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tamper_set,
  input  logic bs_start,
  input  logic idle,
  input  logic enc,
  input  logic key_ok,
  input  logic jtag,
  input  logic cmp,
  input  logic any_key,
  output logic tamper_q,
  output logic accept,
  output logic reject_ev,
  output logic dec_byp,
  output logic dcmp_en,
  output logic dcmp_chain
);

  route_t verdict;
  route_t route_q;
  logic   take;

  assign take      = bs_start && idle;
  assign verdict   = decide(enc, key_ok, jtag, cmp, any_key, tamper_q);
  assign reject_ev = take && !verdict.admit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tamper_q <= 1'b0;
      accept   <= 1'b0;
      route_q  <= ROUTE_IDLE;
    end else begin
      if (tamper_set) tamper_q <= 1'b1;
      accept <= take && verdict.admit;
      if (take) route_q <= verdict;
    end
  end

  assign dec_byp    = route_q.dec_byp;
  assign dcmp_en    = route_q.dcmp_en;
  assign dcmp_chain = route_q.dcmp_chain;

  AST_TAMPER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tamper_q |=> tamper_q); // R9
  AST_CHAIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    dcmp_chain |-> (dcmp_en && !dec_byp)); // R11
  AST_ENC_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (take && enc && !jtag && !any_key) |=> !accept); // R6

endmodule

// File: rtl/cfg_fail_timer.sv
module cfg_fail_timer #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reject_ev,
  output logic idle,
  output logic status_n,
  output logic err_pulse
);

  localparam int CW = $clog2(PULSE_LEN + 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= !busy && reject_ev;
      if (!busy) begin
        if (reject_ev) begin
          busy <= 1'b1;
          cnt  <= CW'(PULSE_LEN - 1);
        end
      end else if (last) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign idle     = !busy;
  assign status_n = !busy;

  AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last) |=> !busy); // R10
  AST_ERR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_n) |-> err_pulse); // R10

endmodule

// File: rtl/cfg_admit_ctrl.sv
module cfg_admit_ctrl
  import cfg_adm_pkg::*;
#(
  parameter int KEY_W     = 256,
  parameter int PULSE_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vol_key_wr,
  input  logic             vol_key_erase,
  input  logic             nv_key_wr,
  input  logic [KEY_W-1:0] key_in,
  input  logic             tamper_set,
  input  logic             bs_start,
  input  logic             bs_encrypted,
  input  logic             bs_key_ok,
  input  logic             bs_from_jtag,
  input  logic             bs_compressed,
  output logic             accept,
  output logic             reject_err,
  output logic             status_n,
  output logic             dec_bypass,
  output logic             dcmp_en,
  output logic             dcmp_after_dec,
  output logic [KEY_W-1:0] key_out,
  output logic             vol_key_valid,
  output logic             nv_key_valid,
  output logic             test_mode_dis
);

  localparam int NSLOT = 2;
  localparam int NV_IX = NSLOT - 1;

  logic [NSLOT-1:0] slot_wr;
  logic [NSLOT-1:0] slot_clr;
  logic [NSLOT-1:0] slot_vld;
  logic [KEY_W-1:0] slot_key [NSLOT];
  logic             any_key;
  logic             idle;
  logic             reject_ev;

  assign slot_wr  = {nv_key_wr, vol_key_wr};
  assign slot_clr = {1'b0, vol_key_erase};

  generate
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      cfg_key_slot #(
        .KEY_W    (KEY_W),
        .ONE_TIME (i == NV_IX)
      ) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (slot_wr[i]),
        .clr   (slot_clr[i]),
        .din   (key_in),
        .key   (slot_key[i]),
        .valid (slot_vld[i])
      );
    end
  endgenerate

  assign any_key       = |slot_vld;
  assign vol_key_valid = slot_vld[0];
  assign nv_key_valid  = slot_vld[NV_IX];
  assign key_out       = slot_vld[NV_IX] ? slot_key[NV_IX] :
                         (slot_vld[0] ? slot_key[0] : '0);

  cfg_adm_policy u_policy (
    .clk        (clk),
    .rst_n      (rst_n),
    .tamper_set (tamper_set),
    .bs_start   (bs_start),
    .idle       (idle),
    .enc        (bs_encrypted),
    .key_ok     (bs_key_ok),
    .jtag       (bs_from_jtag),
    .cmp        (bs_compressed),
    .any_key    (any_key),
    .tamper_q   (test_mode_dis),
    .accept     (accept),
    .reject_ev  (reject_ev),
    .dec_byp    (dec_bypass),
    .dcmp_en    (dcmp_en),
    .dcmp_chain (dcmp_after_dec)
  );

  cfg_fail_timer #(.PULSE_LEN(PULSE_LEN)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .reject_ev (reject_ev),
    .idle      (idle),
    .status_n  (status_n),
    .err_pulse (reject_err)
  );

  AST_TAMPER_PLAIN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bs_start && status_n && test_mode_dis && !bs_encrypted) |=> !accept); // R7
  AST_JTAG_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bs_start && status_n && bs_from_jtag) |=> dec_bypass); // R8
  AST_MISMATCH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (bs_start && status_n && bs_encrypted && !bs_from_jtag && !bs_key_ok) |=> reject_err); // R6

endmodule

// File: tb/tb_cfg_admit_ctrl.sv
module tb_cfg_admit_ctrl;

  localparam int KEY_W = 256;
  localparam int PLEN  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vol_key_wr = 0, vol_key_erase = 0, nv_key_wr = 0, tamper_set = 0;
  logic [KEY_W-1:0] key_in = '0;
  logic bs_start = 0, bs_encrypted = 0, bs_key_ok = 0, bs_from_jtag = 0, bs_compressed = 0;
  logic accept, reject_err, status_n, dec_bypass, dcmp_en, dcmp_after_dec;
  logic [KEY_W-1:0] key_out;
  logic vol_key_valid, nv_key_valid, test_mode_dis;

  always #2.5 clk = ~clk;

  cfg_admit_ctrl #(.KEY_W(KEY_W), .PULSE_LEN(PLEN)) dut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench-side state of the key store and tamper latch
  bit m_vol = 0, m_nv = 0, m_tam = 0;

  typedef struct {
    logic  acc, rej, byp, den, dch;
    int    due;
    string tag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(string req, string what, logic [KEY_W-1:0] act, logic [KEY_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected verdicts when due and compares
  always @(negedge clk) begin
    if (sb.size() > 0 && cyc >= sb[0].due) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, "accept", KEY_W'(accept), KEY_W'(e.acc));
      chk(e.tag, "reject_err", KEY_W'(reject_err), KEY_W'(e.rej));
      chk(e.tag, "status_n", KEY_W'(status_n), KEY_W'(!e.rej));
      chk(e.tag, "dec_bypass", KEY_W'(dec_bypass), KEY_W'(e.byp));
      chk(e.tag, "dcmp_en", KEY_W'(dcmp_en), KEY_W'(e.den));
      chk(e.tag, "dcmp_after_dec", KEY_W'(dcmp_after_dec), KEY_W'(e.dch));
    end
  end

  // driver: one bitstream, expectation derived from the requirements
  task automatic send(bit enc, bit ok, bit jt, bit cm, string tag);
    exp_t e;
    bit pass, via_dec;
    int lowc;
    if (jt)       pass = !m_tam;               // R7 R8
    else if (enc) pass = (m_vol || m_nv) && ok; // R5 R6
    else          pass = !m_tam;               // R4 R7
    via_dec = pass && enc && !jt;
    e.acc = pass; e.rej = !pass;
    e.byp = !via_dec;
    e.den = pass && cm;
    e.dch = pass && cm && via_dec;              // R11
    e.due = cyc + 1; e.tag = tag;
    bs_start = 1; bs_encrypted = enc; bs_key_ok = ok; bs_from_jtag = jt; bs_compressed = cm;
    sb.push_back(e);
    @(negedge clk);
    bs_start = 0; bs_encrypted = 0; bs_key_ok = 0; bs_from_jtag = 0; bs_compressed = 0;
    if (pass) begin
      @(negedge clk);
      chk("R12", "accept one cycle", KEY_W'(accept), '0);
    end else begin
      lowc = 0;
      while (status_n === 1'b0 && lowc < 4 * PLEN) begin
        lowc++;
        @(negedge clk);
        if (lowc == 1) chk("R10", "err one cycle", KEY_W'(reject_err), '0);
        if (lowc == 2) begin bs_start = 1; end
        if (lowc == 3) begin bs_start = 0; end
        if (accept !== 1'b0) chk("R10", "start ignored in window", KEY_W'(accept), '0);
      end
      chk("R10", "status_n low cycles", KEY_W'(lowc), KEY_W'(PLEN));
    end
    @(negedge clk);
  endtask

  task automatic idle_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [KEY_W-1:0] KA = {8{32'hA5A5_0001}};
  localparam logic [KEY_W-1:0] KB = {8{32'h5A5A_1002}};
  localparam logic [KEY_W-1:0] KC = {8{32'hC3C3_2003}};
  localparam logic [KEY_W-1:0] KD = {8{32'h3C3C_4004}};

  task automatic wr_key(bit nv, logic [KEY_W-1:0] k);
    key_in = k;
    if (nv) nv_key_wr = 1; else vol_key_wr = 1;
    @(negedge clk);
    nv_key_wr = 0; vol_key_wr = 0;
    if (nv) m_nv = 1; else m_vol = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R11", "reset dec_bypass", KEY_W'(dec_bypass), KEY_W'(1));
    chk("R11", "reset dcmp_en", KEY_W'(dcmp_en), '0);
    chk("R10", "reset status_n", KEY_W'(status_n), KEY_W'(1));
    chk("R12", "reset accept", KEY_W'(accept), '0);
    chk("R3", "reset key_out", key_out, '0);
    chk("R9", "reset test_mode_dis", KEY_W'(test_mode_dis), '0);

    send(0, 0, 0, 0, "R4 plain no key");
    send(1, 1, 0, 0, "R6 encrypted no key");
    send(0, 0, 0, 1, "R4 idle after window");

    wr_key(0, KA);
    chk("R1", "vol valid", KEY_W'(vol_key_valid), KEY_W'(1));
    chk("R3", "key_out vol", key_out, KA);

    send(1, 1, 0, 1, "R5 R11 enc match cmp");
    send(1, 0, 0, 1, "R6 R11 enc mismatch");
    send(0, 1, 0, 1, "R4 R11 plain cmp");
    send(1, 1, 1, 1, "R8 jtag enc");
    send(1, 1, 0, 0, "R5 enc match");

    // erase and write together: erase wins
    key_in = KB; vol_key_erase = 1; vol_key_wr = 1;
    @(negedge clk);
    vol_key_erase = 0; vol_key_wr = 0; m_vol = 0;
    @(negedge clk);
    chk("R1", "erase wins valid", KEY_W'(vol_key_valid), '0);
    chk("R3", "key_out none", key_out, '0);
    send(1, 1, 0, 0, "R6 enc after erase");
    wr_key(0, KB);
    chk("R1", "rewrite key", key_out, KB);

    wr_key(1, KC);
    chk("R2", "nv valid", KEY_W'(nv_key_valid), KEY_W'(1));
    chk("R3", "nv priority", key_out, KC);
    wr_key(1, KD);
    chk("R2", "nv second write ignored", key_out, KC);
    vol_key_erase = 1;
    @(negedge clk);
    vol_key_erase = 0; m_vol = 0;
    @(negedge clk);
    chk("R2", "nv survives erase", KEY_W'(nv_key_valid), KEY_W'(1));
    chk("R2", "nv key after erase", key_out, KC);
    chk("R1", "vol erased", KEY_W'(vol_key_valid), '0);

    tamper_set = 1;
    @(negedge clk);
    tamper_set = 0; m_tam = 1;
    chk("R9", "test_mode_dis set", KEY_W'(test_mode_dis), KEY_W'(1));
    @(negedge clk);
    send(0, 1, 0, 0, "R7 plain under tamper");
    send(1, 1, 1, 0, "R7 R8 jtag under tamper");
    send(1, 1, 0, 1, "R7 R11 enc match under tamper");
    send(1, 0, 0, 0, "R7 enc mismatch under tamper");
    idle_cyc(20);
    chk("R9", "test_mode_dis sticky", KEY_W'(test_mode_dis), KEY_W'(1));

    idle_cyc(2);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule